// File: doc/BRIEF.md
# Coprocessor Data-Operation Issue Queue

This block is the front end of a small coprocessor attached to a host processor's instruction stream. Every cycle the host may present a 32-bit instruction word together with a flag saying whether that instruction's condition held. The block recognises coprocessor data-operation words that are addressed to its own identity and are condition-true. It pushes each recognised word into a short command queue. The host never waits for a result and gets nothing back. It only keeps issuing.

Behind the queue an execute stage takes one command at a time. Each command holds the stage for a fixed number of cycles. The stage then combines two source registers of a local 16-entry register file, shaped by the opcode and the 3-bit info field, and writes a destination register. The host and the coprocessor therefore run in parallel. When the queue is full, a new matching word is refused, a one-cycle busy pulse is raised and a sticky overflow flag is set. A debug port reads any register combinationally. The idle output tells the surrounding logic when all queued work has drained.

Top module: `cdq_top`

## Requirements
- R1: A word is accepted only when `instr_valid` is high, bits [27:24] equal 4'b1110, bit 4 is 0 and bits [11:8] equal the parameter `CP_ID`. Any other word leaves the queue, the registers and `idle` untouched. Bits [31:28] are not examined.
- R2: A matching word presented with `cond_pass` low is dropped and has no effect.
- R3: The queue holds `QUEUE_DEPTH` (4) commands. A matching word arriving while 4 commands are held is discarded, `busy` is high for exactly that cycle, and `overflow_flag` is set and stays set until reset. Commands already queued still execute.
- R4: The field positions are opcode [23:20], source A [19:16], destination [15:12], info [7:5] and source B [3:0]. Opcode 0 writes A+B+info. Opcode 1 writes A-B-info. Opcodes 2, 3 and 4 write A&B, A|B and A^B. All arithmetic wraps modulo 2^32.
- R5: Opcode 5 copies A. Opcode 6 writes A shifted left by B[4:0]. Opcode 7 writes A shifted logically right by B[4:0].
- R6: Opcodes 8 to 15 write no register and set the sticky `illegal_flag` when they retire.
- R7: Commands execute in issue order, each occupying the execute stage for `EXEC_CYCLES` (2) cycles. With an empty queue, a word accepted at clock edge e writes its destination at edge e+3. Sources are read at retirement, so a command sees the results of every earlier command.
- R8: `idle` is high exactly when the queue is empty and no command is in the execute stage.
- R9: `dbg_data` shows register `dbg_addr` in the same cycle, with no clock delay.
- R10: A synchronous active-high `rst` empties the queue and the execute stage, clears both flags and zeroes all 16 registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Host presents an instruction word this cycle |
| instr_word | input | 32 | Instruction word from the host |
| cond_pass | input | 1 | Host's condition result for this word |
| busy | output | 1 | A matching word was refused this cycle because the queue is full |
| idle | output | 1 | Queue empty and execute stage empty |
| overflow_flag | output | 1 | Sticky: a word was ever refused |
| illegal_flag | output | 1 | Sticky: an undefined opcode retired |
| dbg_addr | input | 4 | Register index for the debug read |
| dbg_data | output | 32 | Contents of the selected register |

## Verification
Two functions can land on the same clock edge: a new word can arrive while the execute stage retires a command and pulls the next one from the queue. The sharpest case is an arrival while the queue is full and a retirement is also happening. An unbroken burst of eight matching words provokes it, because the queue reaches four entries just as the eighth word arrives on a retirement edge. The bench judges it at the ports. It checks that `busy` rises only for the eighth word, that the eighth word's destination stays zero, and that the seven earlier destinations hold their expected sums.

// File: rtl/cdq_pkg.sv
package cdq_pkg;

  localparam int REG_IDX_W = 4;
  localparam int NUM_REGS  = 1 << REG_IDX_W;
  localparam int INFO_W    = 3;
  localparam int ID_W      = 4;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_AND = 4'd2,
    OP_OR  = 4'd3,
    OP_XOR = 4'd4,
    OP_MOV = 4'd5,
    OP_SHL = 4'd6,
    OP_SHR = 4'd7
  } cdq_op_e;

  typedef struct packed {
    cdq_op_e               opc;
    logic [REG_IDX_W-1:0]  src_a;
    logic [REG_IDX_W-1:0]  dst;
    logic [INFO_W-1:0]     info;
    logic [REG_IDX_W-1:0]  src_b;
  } cdq_cmd_t;

  // class bits [27:24] = 1110, bit 4 clear, identity in [11:8]
  function automatic logic word_matches(input logic [31:0] w, input logic [ID_W-1:0] id);
    return (w[27:24] == 4'b1110) && !w[4] && (w[11:8] == id);
  endfunction

  function automatic cdq_cmd_t word_to_cmd(input logic [31:0] w);
    cdq_cmd_t c;
    c.opc   = cdq_op_e'(w[23:20]);
    c.src_a = w[19:16];
    c.dst   = w[15:12];
    c.info  = w[7:5];
    c.src_b = w[3:0];
    return c;
  endfunction

  function automatic logic op_defined(input cdq_op_e o);
    return o <= OP_SHR;
  endfunction

endpackage

// File: rtl/cdq_decode.sv
module cdq_decode
  import cdq_pkg::*;
#(
  parameter logic [ID_W-1:0] CP_ID = 4'd6
) (
  input  logic        instr_valid,
  input  logic [31:0] instr_word,
  input  logic        cond_pass,
  output logic        accept_req,
  output cdq_cmd_t    cmd
);

  // condition code is evaluated by the host; only cond_pass matters here
  logic [3:0] cond_unused;
  assign cond_unused = instr_word[31:28];

  assign accept_req = instr_valid && cond_pass && word_matches(instr_word, CP_ID);
  assign cmd        = word_to_cmd(instr_word);

endmodule

// File: rtl/cdq_fifo.sv
module cdq_fifo
  import cdq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     push,
  input  cdq_cmd_t din,
  input  logic     pop,
  output cdq_cmd_t dout,
  output logic     empty,
  output logic     full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  cdq_cmd_t         mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign dout  = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] next_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= next_ptr(wr_ptr);
      end
      if (pop) rd_ptr <= next_ptr(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/cdq_exec.sv
module cdq_exec
  import cdq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int EXEC_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 fifo_empty,
  input  cdq_cmd_t             head,
  output logic                 pop,
  output logic                 ex_valid,
  output logic                 retire_evt,
  output logic                 retire_illegal,
  output logic                 illegal_flag,
  input  logic [REG_IDX_W-1:0] dbg_addr,
  output logic [DATA_W-1:0]    dbg_data
);

  localparam int SH_W  = $clog2(DATA_W);
  localparam int CNT_W = (EXEC_CYCLES > 1) ? $clog2(EXEC_CYCLES) : 1;

  logic [DATA_W-1:0] rf [NUM_REGS];
  cdq_cmd_t          ex_cmd;
  logic [CNT_W-1:0]  ex_cnt;
  logic [DATA_W-1:0] result;

  function automatic logic [DATA_W-1:0] alu_fn(input cdq_cmd_t c,
                                               input logic [DATA_W-1:0] a,
                                               input logic [DATA_W-1:0] b);
    logic [DATA_W-1:0] inf;
    inf = DATA_W'(c.info);
    case (c.opc)
      OP_ADD:  return a + b + inf;
      OP_SUB:  return a - b - inf;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      OP_MOV:  return a;
      OP_SHL:  return a << b[SH_W-1:0];
      OP_SHR:  return a >> b[SH_W-1:0];
      default: return a;
    endcase
  endfunction

  assign retire_evt     = ex_valid && (ex_cnt == '0);
  assign retire_illegal = !op_defined(ex_cmd.opc);
  assign pop            = !fifo_empty && (!ex_valid || retire_evt);
  assign result         = alu_fn(ex_cmd, rf[ex_cmd.src_a], rf[ex_cmd.src_b]);
  assign dbg_data       = rf[dbg_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid     <= 1'b0;
      ex_cnt       <= '0;
      ex_cmd       <= '0;
      illegal_flag <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) rf[i] <= '0;
    end else begin
      if (pop) begin
        ex_cmd   <= head;
        ex_valid <= 1'b1;
        ex_cnt   <= CNT_W'(EXEC_CYCLES - 1);
      end else if (retire_evt) begin
        ex_valid <= 1'b0;
      end else if (ex_valid) begin
        ex_cnt <= ex_cnt - 1'b1;
      end
      if (retire_evt) begin
        if (retire_illegal) illegal_flag <= 1'b1;
        else                rf[ex_cmd.dst] <= result;
      end
    end
  end

endmodule

// File: rtl/cdq_top.sv
module cdq_top
  import cdq_pkg::*;
#(
  parameter logic [ID_W-1:0] CP_ID       = 4'd6,
  parameter int              DATA_W      = 32,
  parameter int              QUEUE_DEPTH = 4,
  parameter int              EXEC_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instr_valid,
  input  logic [31:0]       instr_word,
  input  logic              cond_pass,
  output logic              busy,
  output logic              idle,
  output logic              overflow_flag,
  output logic              illegal_flag,
  input  logic [3:0]        dbg_addr,
  output logic [DATA_W-1:0] dbg_data
);

  logic     accept_req, push, pop;
  logic     fifo_full, fifo_empty;
  logic     ex_valid, retire_evt, retire_illegal;
  cdq_cmd_t dec_cmd, head_cmd;

  cdq_decode #(.CP_ID(CP_ID)) u_decode (
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .cond_pass   (cond_pass),
    .accept_req  (accept_req),
    .cmd         (dec_cmd)
  );

  assign push = accept_req && !fifo_full;
  assign busy = accept_req && fifo_full;

  cdq_fifo #(.DEPTH(QUEUE_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (push),
    .din   (dec_cmd),
    .pop   (pop),
    .dout  (head_cmd),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  cdq_exec #(.DATA_W(DATA_W), .EXEC_CYCLES(EXEC_CYCLES)) u_exec (
    .clk            (clk),
    .rst            (rst),
    .fifo_empty     (fifo_empty),
    .head           (head_cmd),
    .pop            (pop),
    .ex_valid       (ex_valid),
    .retire_evt     (retire_evt),
    .retire_illegal (retire_illegal),
    .illegal_flag   (illegal_flag),
    .dbg_addr       (dbg_addr),
    .dbg_data       (dbg_data)
  );

  assign idle = fifo_empty && !ex_valid;

  always_ff @(posedge clk) begin
    if (rst)       overflow_flag <= 1'b0;
    else if (busy) overflow_flag <= 1'b1;
  end

endmodule

// File: rtl/cdq_checker.sv
module cdq_checker #(
  parameter int EXEC_CYCLES = 2
) (
  input logic clk,
  input logic rst,
  input logic instr_valid,
  input logic cond_pass,
  input logic busy,
  input logic idle,
  input logic overflow_flag,
  input logic illegal_flag,
  input logic push,
  input logic pop,
  input logic fifo_full,
  input logic fifo_empty,
  input logic ex_valid,
  input logic retire_evt,
  input logic retire_illegal
);

  assert_busy_only_when_full_R3: assert property (@(posedge clk) disable iff (rst)
    busy |-> fifo_full);

  assert_no_push_into_full_R3: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !push);

  assert_busy_sets_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    busy |=> overflow_flag);

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    overflow_flag |=> overflow_flag);

  assert_false_cond_dropped_R2: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && !cond_pass) |-> !push);

  assert_pop_needs_entry_R7: assert property (@(posedge clk) disable iff (rst)
    pop |-> !fifo_empty);

  assert_retire_after_occupancy_R7: assert property (@(posedge clk) disable iff (rst)
    retire_evt |-> ((EXEC_CYCLES == 1) || $past(ex_valid)));

  assert_idle_means_no_retire_R8: assert property (@(posedge clk) disable iff (rst)
    idle |-> !retire_evt);

  assert_illegal_sets_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (retire_evt && retire_illegal) |=> illegal_flag);

  assert_illegal_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    illegal_flag |=> illegal_flag);

endmodule

bind cdq_top cdq_checker #(.EXEC_CYCLES(EXEC_CYCLES)) u_check (
  .clk            (clk),
  .rst            (rst),
  .instr_valid    (instr_valid),
  .cond_pass      (cond_pass),
  .busy           (busy),
  .idle           (idle),
  .overflow_flag  (overflow_flag),
  .illegal_flag   (illegal_flag),
  .push           (push),
  .pop            (pop),
  .fifo_full      (fifo_full),
  .fifo_empty     (fifo_empty),
  .ex_valid       (ex_valid),
  .retire_evt     (retire_evt),
  .retire_illegal (retire_illegal)
);

// File: tb/cdq_top_test.sv
`timescale 1ns/1ps
module cdq_top_test;

  localparam logic [3:0] MY_ID = 4'd6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0;
  logic        cond_pass = 1'b0;
  logic        busy, idle, overflow_flag, illegal_flag;
  logic [3:0]  dbg_addr = '0;
  logic [31:0] dbg_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cdq_top #(.CP_ID(MY_ID), .DATA_W(32), .QUEUE_DEPTH(4), .EXEC_CYCLES(2)) uut (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .cond_pass(cond_pass), .busy(busy), .idle(idle), .overflow_flag(overflow_flag),
    .illegal_flag(illegal_flag), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input int opc, input int rd, input int ra,
                                     input int rb, input int info);
    return {4'b1110, 4'b1110, 4'(opc), 4'(ra), 4'(rd), MY_ID, 3'(info), 1'b0, 4'(rb)};
  endfunction

  task automatic read_reg(input int idx, output logic [31:0] v);
    dbg_addr = 4'(idx);
    #1;
    v = dbg_data;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; instr_valid = 1'b0; cond_pass = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // drive for one cycle; returns at the negedge after the accepting edge
  task automatic issue(input logic [31:0] w, input logic cp);
    @(negedge clk);
    instr_word = w; cond_pass = cp; instr_valid = 1'b1;
    @(negedge clk);
    instr_valid = 1'b0; cond_pass = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60 && !idle; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic test_reset();
    logic [31:0] v;
    do_reset();
    chk("R10", "idle after reset", 32'(idle), 1);
    chk("R10", "busy after reset", 32'(busy), 0);
    chk("R10", "overflow after reset", 32'(overflow_flag), 0);
    chk("R10", "illegal after reset", 32'(illegal_flag), 0);
    issue(mk(0, 3, 0, 0, 4), 1'b1);
    wait_idle();
    read_reg(3, v);
    chk("R9", "debug read r3", v, 4);
    issue(mk(9, 2, 0, 0, 0), 1'b1);
    wait_idle();
    issue(mk(0, 5, 3, 3, 1), 1'b1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    read_reg(3, v);
    chk("R10", "r3 cleared by reset", v, 0);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    read_reg(5, v);
    chk("R10", "queued op discarded by reset", v, 0);
    chk("R10", "illegal cleared by reset", 32'(illegal_flag), 0);
    chk("R10", "idle after mid-run reset", 32'(idle), 1);
  endtask

  task automatic test_timing();
    logic [31:0] v;
    do_reset();
    issue(mk(0, 1, 0, 0, 5), 1'b1);
    chk("R8", "idle low after accept edge", 32'(idle), 0);
    @(negedge clk);
    chk("R8", "idle low while executing", 32'(idle), 0);
    @(negedge clk);
    read_reg(1, v);
    chk("R7", "r1 unchanged at e+2", v, 0);
    @(negedge clk);
    read_reg(1, v);
    chk("R7", "r1 written at e+3", v, 5);
    chk("R8", "idle high after retire", 32'(idle), 1);
    read_reg(0, v);
    chk("R9", "debug port follows address at once", v, 0);
  endtask

  task automatic test_alu();
    logic [31:0] v;
    do_reset();
    issue(mk(0, 1, 0, 0, 6), 1'b1); wait_idle();  // r1 = 6
    issue(mk(0, 2, 0, 0, 3), 1'b1); wait_idle();  // r2 = 3
    issue(mk(0, 9, 0, 0, 1), 1'b1); wait_idle();  // r9 = 1
    issue(mk(0, 3, 1, 2, 0), 1'b1); wait_idle();
    read_reg(3, v); chk("R4", "add 6+3", v, 9);
    issue(mk(1, 4, 1, 2, 0), 1'b1); wait_idle();
    read_reg(4, v); chk("R4", "sub 6-3", v, 3);
    issue(mk(1, 4, 1, 2, 2), 1'b1); wait_idle();
    read_reg(4, v); chk("R4", "sub 6-3-info2", v, 1);
    issue(mk(1, 5, 0, 1, 0), 1'b1); wait_idle();
    read_reg(5, v); chk("R4", "sub wraps 0-6", v, 32'hFFFF_FFFA);
    issue(mk(2, 6, 1, 2, 0), 1'b1); wait_idle();
    read_reg(6, v); chk("R4", "and 6&3", v, 2);
    issue(mk(3, 6, 1, 2, 0), 1'b1); wait_idle();
    read_reg(6, v); chk("R4", "or 6|3", v, 7);
    issue(mk(4, 6, 1, 2, 0), 1'b1); wait_idle();
    read_reg(6, v); chk("R4", "xor 6^3", v, 5);
    issue(mk(5, 7, 1, 2, 7), 1'b1); wait_idle();
    read_reg(7, v); chk("R5", "move r1", v, 6);
    issue(mk(6, 8, 1, 2, 0), 1'b1); wait_idle();
    read_reg(8, v); chk("R5", "shl 6<<3", v, 48);
    issue(mk(7, 8, 1, 9, 0), 1'b1); wait_idle();
    read_reg(8, v); chk("R5", "shr 6>>1", v, 3);
    issue(mk(6, 8, 5, 9, 0), 1'b1); wait_idle();
    read_reg(8, v); chk("R5", "shl top bit falls off", v, 32'hFFFF_FFF4);
    // dependent burst: in order, sources read at retirement
    issue(mk(0, 10, 1, 2, 0), 1'b1);
    issue(mk(0, 11, 10, 10, 1), 1'b1);
    issue(mk(1, 12, 11, 1, 0), 1'b1);
    wait_idle();
    read_reg(12, v); chk("R7", "dependent chain in order", v, 13);
  endtask

  task automatic test_filter();
    logic [31:0] v;
    do_reset();
    issue(mk(0, 13, 0, 0, 7) ^ 32'h0000_0100, 1'b1);
    chk("R1", "idle stays high, wrong identity", 32'(idle), 1);
    issue(mk(0, 13, 0, 0, 7) | 32'h0100_0000, 1'b1);
    chk("R1", "idle stays high, wrong class bits", 32'(idle), 1);
    issue(mk(0, 13, 0, 0, 7) | 32'h0000_0010, 1'b1);
    chk("R1", "idle stays high, bit4 set", 32'(idle), 1);
    issue(mk(0, 13, 0, 0, 7), 1'b0);
    chk("R2", "idle stays high, cond false", 32'(idle), 1);
    @(negedge clk);
    instr_word = mk(0, 13, 0, 0, 7); cond_pass = 1'b1; instr_valid = 1'b0;
    @(negedge clk);
    cond_pass = 1'b0;
    chk("R1", "idle stays high, valid low", 32'(idle), 1);
    wait_idle();
    read_reg(13, v); chk("R1", "r13 untouched by filtered words", v, 0);
    issue(mk(0, 13, 0, 0, 7) & 32'h0FFF_FFFF, 1'b1);
    wait_idle();
    read_reg(13, v); chk("R1", "condition field bits ignored, accepted", v, 7);
  endtask

  task automatic test_illegal();
    logic [31:0] v;
    do_reset();
    issue(mk(0, 1, 0, 0, 2), 1'b1); wait_idle();
    issue(mk(9, 1, 1, 1, 3), 1'b1);
    @(negedge clk);
    chk("R6", "illegal flag low before retire", 32'(illegal_flag), 0);
    @(negedge clk);
    @(negedge clk);
    chk("R6", "illegal flag set at retire", 32'(illegal_flag), 1);
    read_reg(1, v); chk("R6", "r1 not written by opcode 9", v, 2);
    issue(mk(15, 1, 1, 1, 0), 1'b1); wait_idle();
    read_reg(1, v); chk("R6", "r1 not written by opcode 15", v, 2);
    chk("R6", "illegal flag sticky", 32'(illegal_flag), 1);
  endtask

  task automatic test_overflow();
    logic [31:0] v;
    do_reset();
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      instr_word  = mk(0, k + 1, 0, 0, (k < 7) ? k + 1 : 1);
      cond_pass   = 1'b1;
      instr_valid = 1'b1;
      #1;
      chk("R3", $sformatf("busy on burst word %0d", k), 32'(busy), (k == 7) ? 1 : 0);
    end
    @(negedge clk);
    instr_valid = 1'b0; cond_pass = 1'b0;
    chk("R3", "overflow flag set", 32'(overflow_flag), 1);
    #1;
    chk("R3", "busy is a single-cycle pulse", 32'(busy), 0);
    wait_idle();
    for (int k = 0; k < 7; k++) begin
      read_reg(k + 1, v);
      chk("R3", $sformatf("queued word %0d kept", k), v, 32'(k + 1));
    end
    read_reg(8, v); chk("R3", "refused word not executed", v, 0);
    chk("R3", "overflow flag sticky", 32'(overflow_flag), 1);
  endtask

  initial begin
    test_reset();
    test_timing();
    test_alu();
    test_filter();
    test_illegal();
    test_overflow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule